// File: doc/BRIEF.md
# External Interrupt Edge/Level Sensor

This block watches one external pin and turns activity on it into an interrupt flag and an interrupt request for the core. A 2-bit sense field chooses what counts as an event: a low level, any change, a falling edge or a rising edge. The level the block observes is the pad input, or the pad's own driven value when the output driver is enabled. Software can therefore raise an interrupt by driving the pin itself.

While the chip is awake, the pin is synchronised into the system clock domain and then examined for edges or for its level. Edge events set a sticky flag that software clears with a one-cycle clear strobe. In low-level mode the flag simply follows the synchronised pin. The request is the flag gated by an enable bit.

During sleep a separate path samples the pin on a slow auxiliary clock and produces a wake-up pulse. That pulse needs two consecutive slow-clock samples at the required level after the change. The qualified result crosses back into the system clock domain through a synchroniser, and the pulse lasts one system clock cycle.

Top module: `extint_sensor`

## Requirements
- R1: After reset, with the pin idle high, `irq_flag`, `irq_req` and `wake_pulse` are all 0.
- R2: Sense code 00 selects low level. `irq_flag` equals the inverse of the synchronised pin. It is 1 by the second rising clock edge after the pin goes low, and it stays 1 for every cycle the pin is held low.
- R3: Sense code 10 selects falling edge. A 1-to-0 change sets `irq_flag` on the third rising clock edge after the change and not earlier. A 0-to-1 change does not set it.
- R4: Sense code 11 selects rising edge. A 0-to-1 change sets `irq_flag`, and a 1-to-0 change does not.
- R5: Sense code 01 selects any change. A change in either direction sets `irq_flag`, and a steady pin does not.
- R6: In the edge modes `irq_flag` stays set until `flag_clr` is high at a clock edge. If an edge event is taken at the same edge as the clear, the flag stays set.
- R7: `irq_req` is 1 exactly when `irq_flag` and `irq_en` are both 1. Changing `irq_en` does not alter `irq_flag`.
- R8: When `pin_oe` is 1, the observed level is `pin_drv` and `pin_in` is ignored, so a driven edge raises the flag.
- R9: While `sleep_en` is 1, `wake_pulse` goes high for exactly one system clock cycle once two consecutive slow-clock samples show the required level: low for codes 00 and 10, high for 11, and the opposite of the preceding sample for 01. In the edge codes the sample before those two must hold the other level. A pin held low in code 00 gives a single pulse.
- R10: A pin level that is present at only one slow-clock sample does not produce `wake_pulse`.
- R11: `wake_pulse` stays 0 while `sleep_en` is 0.
- R12: While code 00 is selected the edge flag state is held clear. After a switch to an edge code, `irq_flag` reads 0 until a new edge is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset for both clock domains |
| slow_clk | input | 1 | Slow auxiliary clock used for wake-up sampling |
| pin_in | input | 1 | Raw level seen at the pad |
| pin_oe | input | 1 | Pad output driver enabled |
| pin_drv | input | 1 | Value driven onto the pad when `pin_oe` is 1 |
| sense_mode | input | 2 | 00 low level, 01 any change, 10 falling, 11 rising |
| irq_en | input | 1 | Interrupt request enable |
| flag_clr | input | 1 | Clears the sticky edge flag when high at a clock edge |
| sleep_en | input | 1 | Chip is in low-power mode; arms the wake path |
| irq_flag | output | 1 | Interrupt flag |
| irq_req | output | 1 | Interrupt request (flag gated by enable) |
| wake_pulse | output | 1 | One-cycle wake-up pulse in the system clock domain |

## Verification
The bench builds the block with its defaults: a two-stage synchroniser in each direction and two wake samples. With these values the exact flag latency of three clock edges is a fixed number, so the bench checks that the flag is absent one cycle earlier. The slow clock period is set to twenty system cycles and kept off the system clock edges. This lets the bench place a low pulse across exactly one slow sample and show that two matching samples are needed, and show that a held low level produces only one wake pulse.

// File: rtl/extint_pkg.sv
package extint_pkg;

  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_ANY  = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_RISE = 2'b11
  } sense_e;

  // Edge qualification between two consecutive synchronised levels.
  function automatic logic edge_hit(sense_e mode, logic prev_lvl, logic cur_lvl);
    case (mode)
      SENSE_ANY:  return prev_lvl ^ cur_lvl;
      SENSE_FALL: return prev_lvl & ~cur_lvl;
      SENSE_RISE: return ~prev_lvl & cur_lvl;
      default:    return 1'b0;
    endcase
  endfunction

  // Level a wake sample must show; for any-change it is the opposite
  // of the sample taken before the change.
  function automatic logic wake_target(sense_e mode, logic older_lvl);
    case (mode)
      SENSE_RISE: return 1'b1;
      SENSE_ANY:  return ~older_lvl;
      default:    return 1'b0;
    endcase
  endfunction

  // Edge codes demand a prior sample of the other level.
  function automatic logic wake_needs_change(sense_e mode);
    return mode != SENSE_LOW;
  endfunction

endpackage

// File: rtl/extint_sync.sv
module extint_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= {chain_q[STAGES-2:0], d};
  end

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/extint_sense.sv
module extint_sense
  import extint_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   pad_lvl,
  input  sense_e mode,
  input  logic   flag_clr,
  output logic   pin_sync,
  output logic   edge_evt,
  output logic   flag
);

  logic prev_q;
  logic sticky_q;

  extint_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_pin_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pad_lvl),
    .q     (pin_sync)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= pin_sync;
  end

  assign edge_evt = edge_hit(mode, prev_q, pin_sync);

  // Set wins over clear so a coincident event is not lost.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 sticky_q <= 1'b0;
    else if (mode == SENSE_LOW) sticky_q <= 1'b0;
    else if (edge_evt)          sticky_q <= 1'b1;
    else if (flag_clr)          sticky_q <= 1'b0;
  end

  assign flag = (mode == SENSE_LOW) ? ~pin_sync : sticky_q;

endmodule

// File: rtl/extint_wake_qual.sv
module extint_wake_qual
  import extint_pkg::*;
#(
  parameter int WAKE_HITS   = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic   slow_clk,
  input  logic   rst_n,
  input  logic   pad_lvl,
  input  logic   sleep_req,
  input  sense_e mode,
  output logic   wake_req
);

  localparam int HIST_W = WAKE_HITS + 1;

  logic              sleep_slow;
  logic [HIST_W-1:0] hist_q;
  logic [WAKE_HITS-1:0] match;
  logic              target;
  logic              hits_ok;
  logic              change_ok;
  logic              wake_q;

  extint_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sleep_sync (
    .clk   (slow_clk),
    .rst_n (rst_n),
    .d     (sleep_req),
    .q     (sleep_slow)
  );

  always_ff @(posedge slow_clk or negedge rst_n) begin
    if (!rst_n) hist_q <= {HIST_W{1'b1}};
    else        hist_q <= {hist_q[HIST_W-2:0], pad_lvl};
  end

  assign target = wake_target(mode, hist_q[WAKE_HITS]);

  for (genvar i = 0; i < WAKE_HITS; i++) begin : g_match
    assign match[i] = (hist_q[i] == target);
  end

  assign hits_ok   = &match;
  assign change_ok = !wake_needs_change(mode) || (hist_q[WAKE_HITS] != target);

  always_ff @(posedge slow_clk or negedge rst_n) begin
    if (!rst_n) wake_q <= 1'b0;
    else        wake_q <= sleep_slow & hits_ok & change_ok;
  end

  assign wake_req = wake_q;

endmodule

// File: rtl/extint_sensor.sv
module extint_sensor
  import extint_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int WAKE_HITS   = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       slow_clk,
  input  logic       pin_in,
  input  logic       pin_oe,
  input  logic       pin_drv,
  input  logic [1:0] sense_mode,
  input  logic       irq_en,
  input  logic       flag_clr,
  input  logic       sleep_en,
  output logic       irq_flag,
  output logic       irq_req,
  output logic       wake_pulse
);

  sense_e mode;
  logic   pad_lvl;
  logic   pin_sync;
  logic   edge_evt;
  logic   flag;
  logic   wake_req_slow;
  logic   wake_sys;
  logic   wake_prev_q;
  logic   wake_rise;

  assign mode    = sense_e'(sense_mode);
  assign pad_lvl = pin_oe ? pin_drv : pin_in;

  extint_sense #(.SYNC_STAGES(SYNC_STAGES)) u_sense (
    .clk      (clk),
    .rst_n    (rst_n),
    .pad_lvl  (pad_lvl),
    .mode     (mode),
    .flag_clr (flag_clr),
    .pin_sync (pin_sync),
    .edge_evt (edge_evt),
    .flag     (flag)
  );

  extint_wake_qual #(.WAKE_HITS(WAKE_HITS), .SYNC_STAGES(SYNC_STAGES)) u_wake (
    .slow_clk  (slow_clk),
    .rst_n     (rst_n),
    .pad_lvl   (pad_lvl),
    .sleep_req (sleep_en),
    .mode      (mode),
    .wake_req  (wake_req_slow)
  );

  extint_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_wake_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (wake_req_slow),
    .q     (wake_sys)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wake_prev_q <= 1'b0;
    else        wake_prev_q <= wake_sys;
  end

  assign wake_rise  = wake_sys & ~wake_prev_q;
  assign wake_pulse = wake_rise & sleep_en;
  assign irq_flag   = flag;
  assign irq_req    = flag & irq_en;

endmodule

// File: rtl/extint_sensor_chk.sv
module extint_sensor_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] sense_mode,
  input logic       flag_clr,
  input logic       irq_en,
  input logic       sleep_en,
  input logic       irq_flag,
  input logic       irq_req,
  input logic       wake_pulse,
  input logic       pin_sync,
  input logic       edge_evt
);

  a_r2_level_tracks_pin: assert property (@(posedge clk) disable iff (!rst_n)
    (sense_mode == 2'b00) |-> (irq_flag == !pin_sync));

  a_r3_event_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (sense_mode != 2'b00 && edge_evt) |=> (irq_flag || sense_mode == 2'b00));

  a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (sense_mode != 2'b00 && irq_flag && !flag_clr) |=> (irq_flag || sense_mode == 2'b00));

  a_r7_req_gated: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_flag && irq_en));

  a_r9_wake_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |=> !wake_pulse);

  a_r11_wake_needs_sleep: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |-> sleep_en);

  a_r12_level_clears_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (sense_mode == 2'b00) |=> (sense_mode == 2'b00 || !irq_flag || edge_evt || $past(edge_evt)));

endmodule

bind extint_sensor extint_sensor_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sense_mode (sense_mode),
  .flag_clr   (flag_clr),
  .irq_en     (irq_en),
  .sleep_en   (sleep_en),
  .irq_flag   (irq_flag),
  .irq_req    (irq_req),
  .wake_pulse (wake_pulse),
  .pin_sync   (pin_sync),
  .edge_evt   (edge_evt)
);

// File: tb/extint_sensor_bench.sv
`timescale 1ns/1ps
module extint_sensor_bench;

  logic       clk;
  logic       rst_n;
  logic       slow_clk;
  logic       pin_in;
  logic       pin_oe;
  logic       pin_drv;
  logic [1:0] sense_mode;
  logic       irq_en;
  logic       flag_clr;
  logic       sleep_en;
  logic       irq_flag;
  logic       irq_req;
  logic       wake_pulse;

  int checks = 0;
  int errors = 0;
  int wake_cnt = 0;
  bit done = 0;

  extint_sensor u_extint_sensor (
    .clk        (clk),
    .rst_n      (rst_n),
    .slow_clk   (slow_clk),
    .pin_in     (pin_in),
    .pin_oe     (pin_oe),
    .pin_drv    (pin_drv),
    .sense_mode (sense_mode),
    .irq_en     (irq_en),
    .flag_clr   (flag_clr),
    .sleep_en   (sleep_en),
    .irq_flag   (irq_flag),
    .irq_req    (irq_req),
    .wake_pulse (wake_pulse)
  );

  initial begin
    clk = 1'b0;
    forever #10 clk = ~clk;
  end

  // Slow clock: 20 system cycles, edges kept off system clock edges.
  initial begin
    slow_clk = 1'b0;
    #5;
    forever #200 slow_clk = ~slow_clk;
  end

  always @(negedge clk) if (wake_pulse) wake_cnt++;

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic check_int(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clear_pulse();
    flag_clr = 1'b1;
    cycles(1);
    flag_clr = 1'b0;
  endtask

  function automatic string mode_tag(input logic [1:0] m);
    case (m)
      2'b00:   return "R2 low-level";
      2'b01:   return "R5 any-change";
      2'b10:   return "R3 falling";
      default: return "R4 rising";
    endcase
  endfunction

  // {sense[1:0], level before, level after, expected flag}
  localparam logic [4:0] VEC [10] = '{
    {2'b00, 1'b1, 1'b0, 1'b1},
    {2'b00, 1'b0, 1'b1, 1'b0},
    {2'b01, 1'b1, 1'b0, 1'b1},
    {2'b01, 1'b0, 1'b1, 1'b1},
    {2'b01, 1'b0, 1'b0, 1'b0},
    {2'b10, 1'b1, 1'b0, 1'b1},
    {2'b10, 1'b0, 1'b1, 1'b0},
    {2'b10, 1'b1, 1'b1, 1'b0},
    {2'b11, 1'b0, 1'b1, 1'b1},
    {2'b11, 1'b1, 1'b0, 1'b0}
  };

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int base;
    bit bad;
    rst_n = 1'b0; pin_in = 1'b1; pin_oe = 1'b0; pin_drv = 1'b1;
    sense_mode = 2'b10; irq_en = 1'b0; flag_clr = 1'b0; sleep_en = 1'b0;
    cycles(4);
    rst_n = 1'b1;
    cycles(2);

    // R1 reset state
    check("R1 irq_flag", irq_flag, 1'b0);
    check("R1 irq_req", irq_req, 1'b0);
    check("R1 wake_pulse", wake_pulse, 1'b0);

    // Vector table across the sense codes
    irq_en = 1'b1;
    for (int i = 0; i < 10; i++) begin
      sense_mode = VEC[i][4:3];
      pin_in = VEC[i][2];
      cycles(4);
      clear_pulse();
      cycles(1);
      pin_in = VEC[i][1];
      cycles(3);
      check(mode_tag(VEC[i][4:3]), irq_flag, VEC[i][0]);
      check("R7 req follows flag", irq_req, VEC[i][0]);
    end

    // R3 latency: not after two edges, set after three
    irq_en = 1'b0; sense_mode = 2'b10; pin_in = 1'b1;
    cycles(4); clear_pulse(); cycles(1);
    pin_in = 1'b0;
    cycles(2);
    check("R3 flag not early", irq_flag, 1'b0);
    cycles(1);
    check("R3 flag on third edge", irq_flag, 1'b1);
    check("R7 req masked", irq_req, 1'b0);
    irq_en = 1'b1;
    cycles(1);
    check("R7 req enabled", irq_req, 1'b1);
    irq_en = 1'b0;
    cycles(1);
    check("R7 flag kept with enable low", irq_flag, 1'b1);

    // R6 sticky and clear
    pin_in = 1'b1;
    cycles(4);
    check("R6 flag sticky", irq_flag, 1'b1);
    clear_pulse();
    check("R6 clear", irq_flag, 1'b0);

    // R6 event and clear at the same edge
    pin_in = 1'b0;
    cycles(2);
    flag_clr = 1'b1;
    cycles(1);
    flag_clr = 1'b0;
    check("R6 set wins over clear", irq_flag, 1'b1);
    clear_pulse();

    // R2 held low keeps the flag up every cycle
    sense_mode = 2'b00;
    cycles(3);
    bad = 0;
    for (int k = 0; k < 20; k++) begin
      if (irq_flag !== 1'b1) bad = 1;
      cycles(1);
    end
    check("R2 flag held while low", bad, 1'b0);

    // R12 switching to an edge code starts clear
    sense_mode = 2'b10;
    cycles(1);
    check("R12 flag clear after switch", irq_flag, 1'b0);
    pin_in = 1'b1;
    cycles(4);

    // R8 driven pin triggers, raw pad ignored
    pin_drv = 1'b1; pin_oe = 1'b1;
    cycles(4);
    pin_drv = 1'b0;
    cycles(3);
    check("R8 driven edge", irq_flag, 1'b1);
    pin_drv = 1'b1;
    cycles(4);
    clear_pulse();
    pin_in = 1'b0;
    cycles(4);
    pin_in = 1'b1;
    cycles(4);
    check("R8 pad ignored while driving", irq_flag, 1'b0);
    pin_oe = 1'b0;
    cycles(4);

    // R9 falling wake
    sense_mode = 2'b10; pin_in = 1'b1; sleep_en = 1'b1;
    cycles(100);
    base = wake_cnt;
    pin_in = 1'b0;
    cycles(200);
    check_int("R9 falling wake", wake_cnt - base, 1);
    pin_in = 1'b1;
    cycles(100);

    // R10 one low sample only
    base = wake_cnt;
    @(posedge slow_clk);
    #100 pin_in = 1'b0;
    #400 pin_in = 1'b1;
    cycles(200);
    check_int("R10 single sample ignored", wake_cnt - base, 0);

    // R9 low level held gives one pulse
    sense_mode = 2'b00;
    cycles(60);
    base = wake_cnt;
    pin_in = 1'b0;
    cycles(300);
    check_int("R9 level wake single", wake_cnt - base, 1);
    pin_in = 1'b1;
    cycles(100);

    // R9 rising wake
    sense_mode = 2'b11; pin_in = 1'b0;
    cycles(100);
    base = wake_cnt;
    pin_in = 1'b1;
    cycles(200);
    check_int("R9 rising wake", wake_cnt - base, 1);

    // R11 awake: no pulse
    sleep_en = 1'b0; sense_mode = 2'b10;
    cycles(100);
    base = wake_cnt;
    pin_in = 1'b0;
    cycles(200);
    check_int("R11 no wake awake", wake_cnt - base, 0);
    pin_in = 1'b1;
    cycles(10);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule